// File: doc/BRIEF.md
# Per-Channel Privilege Register Access Filter

This block holds the configuration registers of a set of DMA channels and stands between them and the register bus. Every access carries a privilege attribute. Each channel owns one privilege bit in its control register. The block compares the attribute of each access with the privilege bit of the channel it targets. It then either performs the access, masks the read data, or drops the write. Blocked accesses still complete with an ordinary response. No error is signalled.

The privilege bit of every channel is driven out continuously on a status bus, one bit per channel. A small lookup gives the privilege attribute for the master transfers of the channel named by `mst_sel`. The channel datapath only reads the register contents from the flat configuration outputs.

The register bus is a request/response stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Exactly one response follows, raised on the next edge. The response is held with stable data until `rsp_ready` is high. `req_ready` is low only while a response is waiting and `rsp_ready` is low. A new request can therefore be taken in the same cycle the previous response leaves.

Top module: `chan_priv_guard`

## Requirements
- R1: After reset, every register of every channel reads zero, `chan_priv` is all zero, `rsp_valid` is low and `req_ready` is high.
- R2: A privileged write to the control register (offset 0) stores all of its CTRL_W bits, including the privilege bit at bit position 8. The matching `chan_priv` bit follows on the edge that takes the request.
- R3: On an unprivileged channel, unprivileged writes update every register, but the privilege bit keeps the value 0. An unprivileged write of 0xFFFF to control therefore reads back as 0xFEFF.
- R4: On a privileged channel, an unprivileged write to any offset has no effect. The offsets are 0 control, 1 peripheral address, 2 memory address and 3 count. The write leaves both the register outputs and the privilege bit unchanged.
- R5: On a privileged channel, an unprivileged read of control returns only the privilege bit (0x0000_0100). Every other control bit reads as zero.
- R6: On a privileged channel, unprivileged reads of offsets 1, 2 and 3 return zero. Privileged reads of those offsets return the stored values.
- R7: `mst_priv` equals the privilege bit of the channel selected by `mst_sel`, in the same cycle.
- R8: Each accepted request, blocked or not, gives exactly one response on the next edge. A write response carries zero data. While `rsp_ready` is low, the response and its data stay stable and no new request is taken.
- R9: A privileged write can clear the privilege bit. After that, unprivileged reads return the true register values.
- R10: The count register holds COUNT_W (16) bits. Higher write bits are discarded and reads are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged access |
| req_chan | input | 3 | Target channel index |
| req_off | input | 2 | Register offset within the channel |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data after masking; zero for writes |
| chan_priv | output | 8 | Privilege bit of each channel |
| mst_sel | input | 3 | Channel issuing a master transfer |
| mst_priv | output | 1 | Privilege attribute for that transfer |
| ch_ctrl | output | 128 | Control registers, 16 bits per channel |
| ch_paddr | output | 256 | Peripheral address registers, 32 bits per channel |
| ch_maddr | output | 256 | Memory address registers, 32 bits per channel |
| ch_count | output | 128 | Count registers, 16 bits per channel |

## Verification
The bench first tries to raise a channel's privilege bit with an unprivileged write to an open channel. A design that checks only the channel state would let the bit through and lock the channel. On a locked channel it reads every offset unprivileged. A design that masks the whole control word hides the privilege bit, and one that masks nothing leaks addresses. It writes every offset unprivileged, including a control write of zero. A design that missed one offset would change that register or free the channel. Finally, it holds `rsp_ready` low with a second request waiting. A design with a bad handshake would change the response data, lose the waiting request, or take it twice.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  typedef enum logic [1:0] {
    OFF_CTRL  = 2'd0,
    OFF_PADDR = 2'd1,
    OFF_MADDR = 2'd2,
    OFF_COUNT = 2'd3
  } reg_off_e;
endpackage

// File: rtl/cpg_chan_regs.sv
module cpg_chan_regs #(
  parameter int DATA_W   = 32,
  parameter int CTRL_W   = 16,
  parameter int PRIV_POS = 8,
  parameter int COUNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_priv,
  input  logic [1:0]         wr_off,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic [DATA_W-1:0]  paddr_q,
  output logic [DATA_W-1:0]  maddr_q,
  output logic [COUNT_W-1:0] count_q,
  output logic               priv_q
);
  import cpg_pkg::*;

  logic              allow;
  logic [CTRL_W-1:0] ctrl_nxt;

  assign priv_q = ctrl_q[PRIV_POS];
  // a locked channel only listens to privileged writers
  assign allow  = wr_en && (wr_priv || !priv_q);

  always_comb begin
    ctrl_nxt = wr_data[CTRL_W-1:0];
    if (!wr_priv) ctrl_nxt[PRIV_POS] = priv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      paddr_q <= '0;
      maddr_q <= '0;
      count_q <= '0;
    end else if (allow) begin
      case (reg_off_e'(wr_off))
        OFF_CTRL:  ctrl_q  <= ctrl_nxt;
        OFF_PADDR: paddr_q <= wr_data;
        OFF_MADDR: maddr_q <= wr_data;
        default:   count_q <= wr_data[COUNT_W-1:0];
      endcase
    end
  end

  // R4: a locked channel ignores unprivileged writes
  p_locked_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_priv && priv_q) |=>
      ($stable(ctrl_q) && $stable(paddr_q) && $stable(maddr_q) && $stable(count_q)));

  // R3: an unprivileged writer never raises the privilege bit
  p_no_self_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_priv && !priv_q) |=> !priv_q);

  // R2: the privilege bit only rises after a privileged write
  p_rise_needs_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(priv_q) |-> $past(wr_en && wr_priv));
endmodule

// File: rtl/cpg_read_path.sv
module cpg_read_path #(
  parameter int NUM_CH   = 8,
  parameter int CH_W     = 3,
  parameter int DATA_W   = 32,
  parameter int PRIV_POS = 8
) (
  input  logic [CH_W-1:0]               rd_chan,
  input  logic [1:0]                    rd_off,
  input  logic                          rd_priv,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_ext,
  input  logic [NUM_CH-1:0][DATA_W-1:0] paddr,
  input  logic [NUM_CH-1:0][DATA_W-1:0] maddr,
  input  logic [NUM_CH-1:0][DATA_W-1:0] count_ext,
  input  logic [NUM_CH-1:0]             priv,
  output logic [DATA_W-1:0]             rd_data
);
  import cpg_pkg::*;

  localparam logic [DATA_W-1:0] PRIV_ONLY = DATA_W'(1) << PRIV_POS;

  logic [DATA_W-1:0] raw;
  logic              hit;
  logic              locked;

  always_comb begin
    raw    = '0;
    locked = 1'b0;
    hit    = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_chan == CH_W'(i)) begin
        hit    = 1'b1;
        locked = priv[i];
        case (reg_off_e'(rd_off))
          OFF_CTRL:  raw = ctrl_ext[i];
          OFF_PADDR: raw = paddr[i];
          OFF_MADDR: raw = maddr[i];
          default:   raw = count_ext[i];
        endcase
      end
    end
    if (!hit)
      rd_data = '0;
    else if (locked && !rd_priv)
      rd_data = (reg_off_e'(rd_off) == OFF_CTRL) ? (raw & PRIV_ONLY) : '0;
    else
      rd_data = raw;
  end
endmodule

// File: rtl/cpg_master_attr.sv
module cpg_master_attr #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic [NUM_CH-1:0] priv,
  input  logic [CH_W-1:0]   sel,
  output logic              attr
);
  always_comb begin
    attr = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      if (sel == CH_W'(i)) attr = priv[i];
  end
endmodule

// File: rtl/chan_priv_guard.sv
module chan_priv_guard #(
  parameter int NUM_CH   = 8,
  parameter int DATA_W   = 32,
  parameter int CTRL_W   = 16,
  parameter int PRIV_POS = 8,
  parameter int COUNT_W  = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic                        req_priv,
  input  logic [CH_W-1:0]             req_chan,
  input  logic [1:0]                  req_off,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [NUM_CH-1:0]           chan_priv,
  input  logic [CH_W-1:0]             mst_sel,
  output logic                        mst_priv,
  output logic [NUM_CH*CTRL_W-1:0]    ch_ctrl,
  output logic [NUM_CH*DATA_W-1:0]    ch_paddr,
  output logic [NUM_CH*DATA_W-1:0]    ch_maddr,
  output logic [NUM_CH*COUNT_W-1:0]   ch_count
);
  import cpg_pkg::*;

  logic                          take;
  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_ext, paddr_a, maddr_a, count_ext;
  logic [DATA_W-1:0]             rd_data;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CTRL_W-1:0]  c_ctrl;
    logic [COUNT_W-1:0] c_count;
    logic               c_wr;

    assign c_wr = take && req_write && (req_chan == CH_W'(g));

    cpg_chan_regs #(
      .DATA_W(DATA_W), .CTRL_W(CTRL_W), .PRIV_POS(PRIV_POS), .COUNT_W(COUNT_W)
    ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(c_wr), .wr_priv(req_priv),
      .wr_off(req_off), .wr_data(req_wdata), .ctrl_q(c_ctrl),
      .paddr_q(paddr_a[g]), .maddr_q(maddr_a[g]), .count_q(c_count),
      .priv_q(chan_priv[g])
    );

    assign ctrl_ext[g]  = DATA_W'(c_ctrl);
    assign count_ext[g] = DATA_W'(c_count);
    assign ch_ctrl[g*CTRL_W +: CTRL_W]    = c_ctrl;
    assign ch_paddr[g*DATA_W +: DATA_W]   = paddr_a[g];
    assign ch_maddr[g*DATA_W +: DATA_W]   = maddr_a[g];
    assign ch_count[g*COUNT_W +: COUNT_W] = c_count;
  end

  cpg_read_path #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .PRIV_POS(PRIV_POS)
  ) u_rd (
    .rd_chan(req_chan), .rd_off(req_off), .rd_priv(req_priv),
    .ctrl_ext(ctrl_ext), .paddr(paddr_a), .maddr(maddr_a),
    .count_ext(count_ext), .priv(chan_priv), .rd_data(rd_data)
  );

  cpg_master_attr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_mst (
    .priv(chan_priv), .sel(mst_sel), .attr(mst_priv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: every taken request is answered on the next edge
  p_one_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  // R8: a stalled response holds its data
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R6: unprivileged reads of a locked channel's data registers return zero
  p_rd_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write && !req_priv && chan_priv[req_chan] &&
     reg_off_e'(req_off) != OFF_CTRL) |=> (rsp_rdata == '0));
endmodule

// File: tb/tb_chan_priv_guard.sv
module tb_chan_priv_guard;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [2:0]   req_chan = '0, mst_sel = '0;
  logic [1:0]   req_off = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_ready = 1'b1;
  logic         req_ready, rsp_valid, mst_priv;
  logic [31:0]  rsp_rdata;
  logic [7:0]   chan_priv;
  logic [127:0] ch_ctrl, ch_count;
  logic [255:0] ch_paddr, ch_maddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_priv_guard dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_priv(req_priv), .req_chan(req_chan),
    .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .chan_priv(chan_priv),
    .mst_sel(mst_sel), .mst_priv(mst_priv), .ch_ctrl(ch_ctrl),
    .ch_paddr(ch_paddr), .ch_maddr(ch_maddr), .ch_count(ch_count)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one full access with rsp_ready held high; returns the response data
  task automatic access(bit wr, bit pv, int ch, int off, logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_priv = pv;
    req_chan = 3'(ch); req_off = 2'(off); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 response present", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 priv bus", 32'(chan_priv), 32'h0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check("R1 req_ready", 32'(req_ready), 32'h1);
    access(0, 1, 3, 0, '0, d); check("R1 ctrl ch3", d, 32'h0);
    access(0, 1, 6, 2, '0, d); check("R1 maddr ch6", d, 32'h0);
  endtask

  task automatic t_open_channel();
    logic [31:0] d;
    access(1, 0, 2, 0, 32'h0000_FFFF, d);
    check("R8 write rsp zero", d, 32'h0);
    check("R3 priv not raised", 32'(chan_priv), 32'h0);
    access(0, 1, 2, 0, '0, d); check("R3 ctrl readback", d, 32'h0000_FEFF);
    access(1, 0, 2, 1, 32'h1234_5678, d);
    access(0, 0, 2, 1, '0, d); check("R3 paddr unpriv", d, 32'h1234_5678);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    access(1, 1, 5, 0, 32'h0000_0105, d);
    check("R2 priv bus", 32'(chan_priv), 32'h20);
    access(1, 1, 5, 1, 32'hA000_0000, d);
    access(1, 1, 5, 2, 32'h2000_1000, d);
    access(1, 1, 5, 3, 32'h0000_0040, d);
    access(0, 1, 5, 0, '0, d); check("R2 ctrl priv read", d, 32'h0000_0105);
    access(0, 0, 5, 0, '0, d); check("R5 ctrl masked", d, 32'h0000_0100);
    access(0, 0, 5, 1, '0, d); check("R6 paddr masked", d, 32'h0);
    access(0, 0, 5, 2, '0, d); check("R6 maddr masked", d, 32'h0);
    access(0, 0, 5, 3, '0, d); check("R6 count masked", d, 32'h0);
    access(0, 1, 5, 1, '0, d); check("R6 paddr priv", d, 32'hA000_0000);
    access(0, 1, 5, 3, '0, d); check("R6 count priv", d, 32'h40);
  endtask

  task automatic t_blocked_writes();
    logic [31:0] d;
    for (int off = 0; off < 4; off++) access(1, 0, 5, off, 32'h0, d);
    check("R4 priv kept", 32'(chan_priv), 32'h20);
    check("R4 ctrl port", 32'(ch_ctrl[5*16 +: 16]), 32'h0105);
    check("R4 paddr port", ch_paddr[5*32 +: 32], 32'hA000_0000);
    check("R4 maddr port", ch_maddr[5*32 +: 32], 32'h2000_1000);
    check("R4 count port", 32'(ch_count[5*16 +: 16]), 32'h40);
  endtask

  task automatic t_master();
    @(negedge clk); mst_sel = 3'd5; #1;
    check("R7 locked channel attr", 32'(mst_priv), 32'h1);
    mst_sel = 3'd2; #1;
    check("R7 open channel attr", 32'(mst_priv), 32'h0);
  endtask

  task automatic t_count_width();
    logic [31:0] d;
    access(1, 1, 1, 3, 32'hABCD_1234, d);
    access(0, 0, 1, 3, '0, d); check("R10 count width", d, 32'h0000_1234);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    access(1, 1, 5, 0, 32'h0000_0005, d);
    check("R9 priv cleared", 32'(chan_priv), 32'h0);
    access(0, 0, 5, 1, '0, d); check("R9 paddr visible", d, 32'hA000_0000);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_priv = 1'b1;
    req_chan = 3'd2; req_off = 2'd1;
    @(negedge clk);
    check("R8 first rsp", 32'(rsp_valid), 32'h1);
    held = rsp_rdata;
    check("R8 first data", held, 32'h1234_5678);
    req_chan = 3'd5; req_off = 2'd2;
    repeat (3) @(negedge clk);
    check("R8 stall ready low", 32'(req_ready), 32'h0);
    check("R8 stall data held", rsp_rdata, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 second rsp", 32'(rsp_valid), 32'h1);
    check("R8 second data", rsp_rdata, 32'h2000_1000);
    @(negedge clk);
    check("R8 single rsp", 32'(rsp_valid), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_open_channel();
    t_lock();
    t_blocked_writes();
    t_master();
    t_count_width();
    t_unlock();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule